// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a set of free-running clock sources and the chip's clock output drivers. Each gated output has its own enable bit, driven from a control register. When a bit is cleared, that output is parked low. A global active-low power-down pin stops every output at once. The gating only ever acts while the source clock is low, so every high pulse that leaves the block has full width.

A differential CPU clock pair gets special treatment. The true and complement outputs share one enable bit. Under power-down, their parked state depends on two static configuration inputs, a processor-mode bit and a float-select bit. The pair can park low and driven, park with the true side held high and the complement undriven, or float on both sides. The block also raises a shutdown status. Downstream logic, such as the serial control port, uses this status to disable itself.

The power-down pin is treated as asynchronous. It counts only after it has been seen low on two consecutive rising edges of the CPU clock.

Top module: `clk_stop_ctrl`

## Requirements
- R1: Clearing bit i of `out_en_i` parks `clk_o[i]` low after at most two source periods, while the other outputs keep toggling; setting it again restarts the output.
- R2: No gated output ever produces a short pulse. Every high pulse of `clk_o[i]` lasts exactly one source high phase, and every low time lasts at least one source low phase. Every high and low time of `cpu_t_o` and `cpu_c_o` lasts at least half a CPU period.
- R3: Power-down is qualified only when `pd_ni` is sampled low on two consecutive rising edges of `cpu_clk_i`. A low level seen on a single edge has no effect on `shutdown_o` or on any output.
- R4: Once power-down is qualified, every `clk_o` output stops low at one of its own falling edges and stays low.
- R5: With `mode_p4_i`=1 and `cpu_hiz_i`=0, qualified power-down holds `cpu_t_o` high with `cpu_t_oe_o`=1, and drives `cpu_c_oe_o` to 0 (complement undriven).
- R6: With `mode_p4_i`=1 and `cpu_hiz_i`=1, qualified power-down drives both `cpu_t_oe_o` and `cpu_c_oe_o` to 0.
- R7: With `mode_p4_i`=0, qualified power-down parks `cpu_t_o` and `cpu_c_o` low with both output enables at 1.
- R8: The qualifier clears at the first CPU rising edge that samples `pd_ni` high. Each output then resumes with a complete high pulse, and both CPU output enables return to 1.
- R9: `shutdown_o` is 1 exactly while power-down is qualified.
- R10: Asynchronous reset (`rst_ni`=0) clears the qualifier and sets every gate to running. After reset, with all enables at 1, every output toggles and `shutdown_o` is 0.
- R11: `cpu_en_i`=0 parks both `cpu_t_o` and `cpu_c_o` low, with both output enables kept at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | CPU reference clock; also qualifies power-down |
| src_clk_i | input | N_OUT | Free-running source clocks, one per gated output |
| out_en_i | input | N_OUT | Per-output enable, 1 = running |
| cpu_en_i | input | 1 | Enable for the CPU pair, 1 = running |
| pd_ni | input | 1 | Asynchronous active-low power-down request |
| mode_p4_i | input | 1 | Processor mode: 1 = hold-high stop, 0 = stop low |
| cpu_hiz_i | input | 1 | In mode 1, float both CPU outputs under power-down |
| clk_o | output | N_OUT | Gated clocks |
| cpu_t_o | output | 1 | CPU clock, true side |
| cpu_c_o | output | 1 | CPU clock, complement side |
| cpu_t_oe_o | output | 1 | Driver enable for `cpu_t_o` |
| cpu_c_oe_o | output | 1 | Driver enable for `cpu_c_o` |
| shutdown_o | output | 1 | Power-down qualified; disables the serial control port |

## Verification
The gating is exercised with single-bit and multi-bit clears of the enable vector, on sources of four unrelated periods. This separates a gate that follows its own bit from one that is cross-wired to a neighbour. Power-down is applied once as a pulse covering a single CPU edge and once as a sustained low, which tells a two-edge qualifier apart from a one-edge one. The sustained case is repeated under each combination of mode and float select, so the three CPU park states are each distinguished by level and driver enable. A pulse-width monitor runs across the whole sequence and catches any shortened pulse at a stop or a restart.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

  typedef enum logic [1:0] {
    CPU_RUN     = 2'd0,
    CPU_LOW     = 2'd1,
    CPU_HOLD_HI = 2'd2,
    CPU_FLOAT   = 2'd3
  } cpu_stop_e;

  function automatic cpu_stop_e stop_decode(logic qual, logic p4, logic hiz);
    if (!qual) return CPU_RUN;
    if (!p4)   return CPU_LOW;
    return hiz ? CPU_FLOAT : CPU_HOLD_HI;
  endfunction

endpackage

// File: rtl/csc_pd_qual.sv
module csc_pd_qual #(
  parameter int QUAL_EDGES = 2
) (
  input  logic rst_ni,
  input  logic clk_i,
  input  logic pd_ni,
  output logic qual_o
);
  localparam int HW = QUAL_EDGES - 1;

  logic [HW-1:0] hist_q;
  logic          qual_q;

  generate
    if (HW == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= ~pd_ni;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= {hist_q[HW-2:0], ~pd_ni};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) qual_q <= 1'b0;
    else         qual_q <= (&hist_q) & ~pd_ni;

  assign qual_o = qual_q;

  generate
    if (QUAL_EDGES == 2) begin : g_chk
      assert_pd_two_edges_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(qual_q) |-> ($past(pd_ni, 1) == 1'b0) && ($past(pd_ni, 2) == 1'b0));
    end
  endgenerate

  assert_pd_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_q |-> ($past(pd_ni) == 1'b0));

endmodule

// File: rtl/csc_gate_cell.sv
module csc_gate_cell (
  input  logic rst_ni,
  input  logic clk_i,
  input  logic want_i,
  output logic gclk_o,
  output logic run_o
);
  logic sync_q, run_q;

  // capture on rise, apply on fall: enable moves only while clock is low
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= 1'b1;
    else         sync_q <= want_i;

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) run_q <= 1'b1;
    else         run_q <= sync_q;

  assign gclk_o = clk_i & run_q;
  assign run_o  = run_q;

  assert_stop_at_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_q) |-> !run_q);

  assert_start_at_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |-> run_q);

endmodule

// File: rtl/csc_cpu_pair.sv
module csc_cpu_pair
  import clk_stop_pkg::*;
(
  input  logic rst_ni,
  input  logic cpu_clk_i,
  input  logic cpu_en_i,
  input  logic pd_qual_i,
  input  logic mode_p4_i,
  input  logic cpu_hiz_i,
  output logic cpu_t_o,
  output logic cpu_c_o,
  output logic t_oe_o,
  output logic c_oe_o
);
  cpu_stop_e stop_sel;
  logic      want, cpu_clk_n;
  logic      gt, run_t, gc, run_c;
  logic      hold_q, t_oe_q, c_oe_q;

  assign stop_sel  = stop_decode(pd_qual_i, mode_p4_i, cpu_hiz_i);
  assign want      = cpu_en_i & (stop_sel == CPU_RUN);
  assign cpu_clk_n = ~cpu_clk_i;

  csc_gate_cell u_gate_t (.rst_ni(rst_ni), .clk_i(cpu_clk_i), .want_i(want), .gclk_o(gt), .run_o(run_t));
  csc_gate_cell u_gate_c (.rst_ni(rst_ni), .clk_i(cpu_clk_n), .want_i(want), .gclk_o(gc), .run_o(run_c));

  // hold rises with a clock rise; released only once the gate runs again
  always_ff @(posedge cpu_clk_i or negedge rst_ni)
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= (stop_sel == CPU_HOLD_HI) | (hold_q & ~run_t & cpu_en_i);

  always_ff @(posedge cpu_clk_i or negedge rst_ni)
    if (!rst_ni) begin
      t_oe_q <= 1'b1;
      c_oe_q <= 1'b1;
    end else begin
      t_oe_q <= (stop_sel != CPU_FLOAT);
      c_oe_q <= (stop_sel == CPU_RUN) || (stop_sel == CPU_LOW);
    end

  assign cpu_t_o = gt | hold_q;
  assign cpu_c_o = gc;
  assign t_oe_o  = t_oe_q;
  assign c_oe_o  = c_oe_q;

  assert_t_held_high_R5: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    pd_qual_i && $past(pd_qual_i) && mode_p4_i && !cpu_hiz_i |-> cpu_t_o && t_oe_o);

  assert_c_undriven_R5: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    pd_qual_i && $past(pd_qual_i) && mode_p4_i |-> !c_oe_o);

  assert_pair_float_R6: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    pd_qual_i && $past(pd_qual_i) && mode_p4_i && cpu_hiz_i |-> !t_oe_o && !c_oe_o);

  assert_pair_low_R7: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    pd_qual_i && $past(pd_qual_i) && !mode_p4_i |-> !cpu_t_o && !cpu_c_o && t_oe_o && c_oe_o);

  unused_run_c: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    $fell(run_c) |-> !cpu_c_o);

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int N_OUT      = 4,
  parameter int QUAL_EDGES = 2
) (
  input  logic             rst_ni,
  input  logic             cpu_clk_i,
  input  logic [N_OUT-1:0] src_clk_i,
  input  logic [N_OUT-1:0] out_en_i,
  input  logic             cpu_en_i,
  input  logic             pd_ni,
  input  logic             mode_p4_i,
  input  logic             cpu_hiz_i,
  output logic [N_OUT-1:0] clk_o,
  output logic             cpu_t_o,
  output logic             cpu_c_o,
  output logic             cpu_t_oe_o,
  output logic             cpu_c_oe_o,
  output logic             shutdown_o
);
  logic             pd_qual;
  logic [N_OUT-1:0] run_unused;

  csc_pd_qual #(.QUAL_EDGES(QUAL_EDGES)) u_pd_qual (
    .rst_ni(rst_ni), .clk_i(cpu_clk_i), .pd_ni(pd_ni), .qual_o(pd_qual)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_gate
    csc_gate_cell u_gate (
      .rst_ni(rst_ni),
      .clk_i (src_clk_i[i]),
      .want_i(out_en_i[i] & ~pd_qual),
      .gclk_o(clk_o[i]),
      .run_o (run_unused[i])
    );
  end

  csc_cpu_pair u_cpu_pair (
    .rst_ni(rst_ni), .cpu_clk_i(cpu_clk_i), .cpu_en_i(cpu_en_i),
    .pd_qual_i(pd_qual), .mode_p4_i(mode_p4_i), .cpu_hiz_i(cpu_hiz_i),
    .cpu_t_o(cpu_t_o), .cpu_c_o(cpu_c_o), .t_oe_o(cpu_t_oe_o), .c_oe_o(cpu_c_oe_o)
  );

  assign shutdown_o = pd_qual;

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    assert_out_low_when_idle_R4: assert property (@(posedge src_clk_i[i]) disable iff (!rst_ni)
      !run_unused[i] |-> !clk_o[i]);
  end

endmodule

// File: tb/clk_stop_ctrl_bench.sv
`timescale 1ns/1ps
module clk_stop_ctrl_bench;
  localparam int N = 4;
  localparam real WIN = 100.0;

  logic rst_n = 1'b0;
  logic cpu_clk = 1'b0;
  logic s0 = 0, s1 = 0, s2 = 0, s3 = 0;
  logic [N-1:0] src_clk;
  logic [N-1:0] out_en = '1;
  logic cpu_en = 1'b1, pd_n = 1'b1, mode_p4 = 1'b1, cpu_hiz = 1'b0;
  logic [N-1:0] clk_o;
  logic cpu_t, cpu_c, t_oe, c_oe, shutdown;

  always #2.5 cpu_clk = ~cpu_clk;
  always #5   s0 = ~s0;
  always #7   s1 = ~s1;
  always #10  s2 = ~s2;
  always #3   s3 = ~s3;
  assign src_clk = {s3, s2, s1, s0};

  clk_stop_ctrl #(.N_OUT(N)) u_clk_stop_ctrl (
    .rst_ni(rst_n), .cpu_clk_i(cpu_clk), .src_clk_i(src_clk), .out_en_i(out_en),
    .cpu_en_i(cpu_en), .pd_ni(pd_n), .mode_p4_i(mode_p4), .cpu_hiz_i(cpu_hiz),
    .clk_o(clk_o), .cpu_t_o(cpu_t), .cpu_c_o(cpu_c), .cpu_t_oe_o(t_oe),
    .cpu_c_oe_o(c_oe), .shutdown_o(shutdown)
  );

  int total = 0, bad = 0, runts = 0;
  int cnt [0:6];
  initial for (int k = 0; k < 7; k++) cnt[k] = 0;

  // activity counters: 0..3 clk_o, 4 cpu_t, 5 cpu_c, 6 shutdown
  logic [6:0] mon_sig;
  assign mon_sig = {shutdown, cpu_c, cpu_t, clk_o};
  for (genvar g = 0; g < 7; g++) begin : g_cnt
    always @(posedge mon_sig[g]) cnt[g]++;
  end

  // R2 pulse-width monitor
  real half_r [0:5];
  initial begin
    half_r[0] = 5.0; half_r[1] = 7.0; half_r[2] = 10.0; half_r[3] = 3.0;
    half_r[4] = 2.5; half_r[5] = 2.5;
  end
  for (genvar g = 0; g < 6; g++) begin : g_width
    real tr = -1.0, tf = -1.0;
    always @(posedge mon_sig[g]) begin
      if (rst_n && tf >= 0.0 && ($realtime - tf) < half_r[g] - 0.01) begin
        runts++;
        $display("width violation low idx=%0d w=%0.2f", g, $realtime - tf);
      end
      tr = $realtime;
    end
    always @(negedge mon_sig[g]) begin
      if (rst_n && tr >= 0.0) begin
        real w;
        w = $realtime - tr;
        if ((g < 4 && (w > half_r[g] + 0.01 || w < half_r[g] - 0.01)) ||
            (g >= 4 && w < half_r[g] - 0.01)) begin
          runts++;
          $display("width violation high idx=%0d w=%0.2f", g, w);
        end
      end
      tf = $realtime;
    end
  end

  typedef struct {
    int    idx;
    bit    chk_act;
    bit    exp_act;
    bit    chk_lvl;
    bit    exp_lvl;
    int    start;
    string req;
  } exp_t;
  exp_t sb_q[$];
  event sb_ev;

  function automatic logic level_of(int idx);
    case (idx)
      0, 1, 2, 3: return clk_o[idx];
      4: return cpu_t;
      5: return cpu_c;
      6: return shutdown;
      7: return t_oe;
      default: return c_oe;
    endcase
  endfunction

  function automatic int cnt_of(int idx);
    return (idx < 7) ? cnt[idx] : 0;
  endfunction

  // monitor: pops expectations and compares with what the design produced
  initial forever begin
    @(sb_ev);
    while (sb_q.size() > 0) begin
      exp_t it;
      bit act, lvl;
      it  = sb_q.pop_front();
      act = (cnt_of(it.idx) - it.start) > 0;
      lvl = level_of(it.idx);
      total++;
      if ((it.chk_act && act != it.exp_act) || (it.chk_lvl && lvl != it.exp_lvl)) begin
        bad++;
        $display("FAIL %s idx=%0d act=%0b/%0b lvl=%0b/%0b (actual/expected)",
                 it.req, it.idx, act, it.exp_act, lvl, it.exp_lvl);
      end
    end
  end

  task automatic push(int idx, bit ca, bit ea, bit cl, bit el, int start, string req);
    exp_t it;
    it.idx = idx; it.chk_act = ca; it.exp_act = ea; it.chk_lvl = cl;
    it.exp_lvl = el; it.start = start; it.req = req;
    sb_q.push_back(it);
    -> sb_ev;
  endtask

  task automatic observe(int idx, bit ca, bit ea, bit cl, bit el, string req);
    int s;
    s = cnt_of(idx);
    #(WIN);
    push(idx, ca, ea, cl, el, s, req);
    #0.1;
  endtask

  task automatic settle();
    #100;
  endtask

  task automatic pd_set(logic v);
    @(negedge cpu_clk);
    pd_n = v;
    settle();
  endtask

  task automatic all_running(string req);
    for (int k = 0; k < 6; k++) observe(k, 1, 1, 0, 0, req);
  endtask

  task automatic outs_stopped(string req);
    for (int k = 0; k < 4; k++) observe(k, 1, 0, 1, 0, req);
  endtask

  bit done = 0;
  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #22 rst_n = 1'b1;
    settle();

    // R10 reset state
    push(6, 0, 0, 1, 0, 0, "R10 shutdown after reset");
    all_running("R10 running after reset");

    // R1 single clear, then a two-bit pattern
    out_en = 4'b1101; settle();
    observe(1, 1, 0, 1, 0, "R1 cleared output parked low");
    observe(0, 1, 1, 0, 0, "R1 neighbour keeps running");
    observe(2, 1, 1, 0, 0, "R1 neighbour keeps running");
    out_en = 4'b0110; settle();
    observe(0, 1, 0, 1, 0, "R1 bit0 cleared");
    observe(3, 1, 0, 1, 0, "R1 bit3 cleared");
    observe(1, 1, 1, 0, 0, "R1 bit1 restarted");
    out_en = 4'b1111; settle();

    // R11 CPU pair disable
    cpu_en = 1'b0; settle();
    observe(4, 1, 0, 1, 0, "R11 cpu_t parked low");
    observe(5, 1, 0, 1, 0, "R11 cpu_c parked low");
    push(7, 0, 0, 1, 1, 0, "R11 t_oe kept");
    push(8, 0, 0, 1, 1, 0, "R11 c_oe kept");
    cpu_en = 1'b1; settle();

    // R3 low level seen on one edge only
    begin
      int s;
      s = cnt[6];
      @(negedge cpu_clk) pd_n = 1'b0;
      @(negedge cpu_clk) pd_n = 1'b1;
      #50;
      push(6, 1, 0, 1, 0, s, "R3 single-edge low ignored");
    end
    all_running("R3 outputs unaffected");

    // R4 R5 R9 hold-high park
    pd_set(1'b0);
    push(6, 0, 0, 1, 1, 0, "R9 shutdown while qualified");
    outs_stopped("R4 outputs parked");
    observe(4, 1, 0, 1, 1, "R5 cpu_t held high");
    push(7, 0, 0, 1, 1, 0, "R5 t_oe driven");
    push(8, 0, 0, 1, 0, 0, "R5 c undriven");
    pd_set(1'b1);
    push(6, 0, 0, 1, 0, 0, "R9 shutdown released");
    push(7, 0, 0, 1, 1, 0, "R8 t_oe back");
    push(8, 0, 0, 1, 1, 0, "R8 c_oe back");
    all_running("R8 resumed");

    // R6 float park
    cpu_hiz = 1'b1; settle();
    pd_set(1'b0);
    push(7, 0, 0, 1, 0, 0, "R6 t floated");
    push(8, 0, 0, 1, 0, 0, "R6 c floated");
    outs_stopped("R4 outputs parked in float mode");
    pd_set(1'b1);
    all_running("R8 resumed after float");
    cpu_hiz = 1'b0; settle();

    // R7 stop-low mode
    mode_p4 = 1'b0; settle();
    pd_set(1'b0);
    observe(4, 1, 0, 1, 0, "R7 cpu_t low");
    observe(5, 1, 0, 1, 0, "R7 cpu_c low");
    push(7, 0, 0, 1, 1, 0, "R7 t_oe driven");
    push(8, 0, 0, 1, 1, 0, "R7 c_oe driven");
    outs_stopped("R4 outputs parked in stop-low mode");
    pd_set(1'b1);
    all_running("R8 resumed after stop-low");

    // R2 whole-run pulse widths
    total++;
    if (runts != 0) begin
      bad++;
      $display("FAIL R2 width violations actual=%0d expected=0", runts);
    end

    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule